// File: doc/BRIEF.md
# Capability Access Guard

This block decides whether a memory access made through a capability may proceed. A capability is a 128-bit pointer token that carries a current address, a lower bound, a length and four permission bits. A single validity tag travels beside it, outside the 128 data bits. The requester presents the capability, its tag, an access kind (load, store or fetch) and an access size in bytes. One cycle later the block returns either a clear verdict or one fault cause code. The cause is fixed, so a given request faults on every attempt.

The block also has a second, independent path that derives a narrower capability from an existing one. The caller supplies a new lower bound, a new length and a new permission set. The result always carries the new fields and keeps the source address. Its tag survives only when the source was tagged and the new rights are no wider than the old ones. Because of this rule, an untagged value can never become valid, and bounds or rights can only shrink.

Top module: `cap_guard`

## Requirements
- R1: Capability layout: address in bits [63:0], lower bound in [95:64], length in [123:96], and permissions in [127:124], with bit 124 read, 125 write, 126 execute and 127 seal.
- R2: Each path registers its result. A request in cycle n gives a one-cycle valid pulse and the result in cycle n+1. With no request, the valid output is low and the previous result is held.
- R3: A check request whose tag input is 0 reports cause 1 (tag clear).
- R4: A tagged check request on a capability with the seal bit set reports cause 2 (sealed), for any access kind.
- R5: Access kind 0 (load) needs read, kind 1 (store) needs write and kind 2 (fetch) needs execute. Kind 3 always lacks permission. A missing permission reports cause 3.
- R6: An access of N bytes at address A passes bounds only if bound <= A and A+N <= bound+length, computed without wraparound. Any other case reports cause 4. An access ending exactly at bound+length passes.
- R7: Causes are ranked 1, 2, 3, 4, and the lowest-numbered failing check is reported. When every check passes, the cause is 0 and the ok output is 1. Otherwise ok is 0.
- R8: A derived capability keeps its tag only if the source tag is set, new bound >= old bound, new bound+new length <= old bound+old length (without wraparound), and the new permissions are a subset of the old ones. In every other case the tag is 0.
- R9: The derived capability carries the new bound, length and permissions, and the unchanged source address, whatever its tag.
- R10: While reset is asserted, every output is 0.
- R11: A check and a derive presented in the same cycle both complete, and each gives the same result it would give alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_valid_i | input | 1 | Check request strobe |
| chk_cap_i | input | 128 | Capability used for the access |
| chk_tag_i | input | 1 | Validity tag of chk_cap_i |
| chk_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| chk_size_i | input | 5 | Access size in bytes |
| chk_valid_o | output | 1 | Check result strobe |
| chk_cause_o | output | 3 | Fault cause: 0 none, 1 tag, 2 sealed, 3 permission, 4 bounds |
| chk_ok_o | output | 1 | Access allowed |
| drv_valid_i | input | 1 | Derive request strobe |
| drv_cap_i | input | 128 | Source capability |
| drv_tag_i | input | 1 | Validity tag of the source |
| drv_base_i | input | 32 | Requested lower bound |
| drv_len_i | input | 28 | Requested length |
| drv_perm_i | input | 4 | Requested permissions |
| drv_valid_o | output | 1 | Derive result strobe |
| drv_cap_o | output | 128 | Derived capability |
| drv_tag_o | output | 1 | Validity tag of the derived capability |

## Verification
The check and the derive can be requested in the same cycle. The bench provokes this by issuing both strobes together, in directed cases and in a long randomized stretch. In the directed cases the derive targets the same capability that the check reads. A behavioural model in the bench computes both results independently, cycle by cycle. The bench then compares each output against the model, and also checks that the cause and the tag together match the model's values, so one path cannot disturb the other.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int ADDR_W = 64;
  localparam int BASE_W = 32;
  localparam int LEN_W  = 28;
  localparam int PERM_W = 4;
  localparam int CAP_W  = ADDR_W + BASE_W + LEN_W + PERM_W;

  // permission bit positions inside the perm field
  localparam int P_RD   = 0;
  localparam int P_WR   = 1;
  localparam int P_EX   = 2;
  localparam int P_SEAL = 3;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_TAG    = 3'd1,
    FLT_SEAL   = 3'd2,
    FLT_PERM   = 3'd3,
    FLT_BOUNDS = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic [PERM_W-1:0] perm;
    logic [LEN_W-1:0]  len;
    logic [BASE_W-1:0] base;
    logic [ADDR_W-1:0] addr;
  } cap_t;
endpackage

// File: rtl/cap_bounds_chk.sv
module cap_bounds_chk import cap_pkg::*; #(
  parameter int SIZE_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              in_bounds_o
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] acc_end, cap_top;
  logic             lo_ok, hi_ok;

  // one extra bit so neither sum can wrap
  always_comb begin
    acc_end = {1'b0, addr_i} + EXT_W'(size_i);
    cap_top = EXT_W'(base_i) + EXT_W'(len_i);
    lo_ok   = addr_i >= ADDR_W'(base_i);
    hi_ok   = acc_end <= cap_top;
  end

  assign in_bounds_o = lo_ok & hi_ok;
endmodule

// File: rtl/cap_perm_chk.sv
module cap_perm_chk import cap_pkg::*; (
  input  logic [PERM_W-1:0] perm_i,
  input  logic [1:0]        kind_i,
  output logic              sealed_o,
  output logic              perm_ok_o
);
  always_comb begin
    sealed_o = perm_i[P_SEAL];
    unique case (acc_e'(kind_i))
      ACC_LOAD:  perm_ok_o = perm_i[P_RD];
      ACC_STORE: perm_ok_o = perm_i[P_WR];
      ACC_FETCH: perm_ok_o = perm_i[P_EX];
      default:   perm_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_derive.sv
module cap_derive import cap_pkg::*; (
  input  cap_t              src_i,
  input  logic              src_tag_i,
  input  logic [BASE_W-1:0] new_base_i,
  input  logic [LEN_W-1:0]  new_len_i,
  input  logic [PERM_W-1:0] new_perm_i,
  output cap_t              res_o,
  output logic              res_tag_o
);
  localparam int TOP_W = BASE_W + 1;

  logic [TOP_W-1:0] old_top, new_top;
  logic             lo_ok, hi_ok, perm_ok;

  always_comb begin
    old_top = TOP_W'(src_i.base) + TOP_W'(src_i.len);
    new_top = TOP_W'(new_base_i) + TOP_W'(new_len_i);
    lo_ok   = new_base_i >= src_i.base;
    hi_ok   = new_top <= old_top;
    perm_ok = ~|(new_perm_i & ~src_i.perm);
  end

  always_comb begin
    res_o      = src_i;
    res_o.base = new_base_i;
    res_o.len  = new_len_i;
    res_o.perm = new_perm_i;
  end

  // monotonic rule: only a tagged source that is narrowed keeps the tag
  assign res_tag_o = src_tag_i & lo_ok & hi_ok & perm_ok;
endmodule

// File: rtl/cap_guard.sv
module cap_guard import cap_pkg::*; #(
  parameter int SIZE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_valid_i,
  input  logic [CAP_W-1:0]  chk_cap_i,
  input  logic              chk_tag_i,
  input  logic [1:0]        chk_kind_i,
  input  logic [SIZE_W-1:0] chk_size_i,
  output logic              chk_valid_o,
  output logic [2:0]        chk_cause_o,
  output logic              chk_ok_o,
  input  logic              drv_valid_i,
  input  logic [CAP_W-1:0]  drv_cap_i,
  input  logic              drv_tag_i,
  input  logic [BASE_W-1:0] drv_base_i,
  input  logic [LEN_W-1:0]  drv_len_i,
  input  logic [PERM_W-1:0] drv_perm_i,
  output logic              drv_valid_o,
  output logic [CAP_W-1:0]  drv_cap_o,
  output logic              drv_tag_o
);
  cap_t   chk_cap, drv_src, drv_res;
  logic   in_bounds, sealed, perm_ok, drv_res_tag;
  fault_e cause_d, cause_q;
  logic   chk_vq, ok_q, drv_vq, drv_tag_q;
  cap_t   drv_cap_q;

  assign chk_cap = cap_t'(chk_cap_i);
  assign drv_src = cap_t'(drv_cap_i);

  cap_bounds_chk #(.SIZE_W(SIZE_W)) u_bounds (
    .addr_i      (chk_cap.addr),
    .base_i      (chk_cap.base),
    .len_i       (chk_cap.len),
    .size_i      (chk_size_i),
    .in_bounds_o (in_bounds)
  );

  cap_perm_chk u_perm (
    .perm_i    (chk_cap.perm),
    .kind_i    (chk_kind_i),
    .sealed_o  (sealed),
    .perm_ok_o (perm_ok)
  );

  cap_derive u_derive (
    .src_i      (drv_src),
    .src_tag_i  (drv_tag_i),
    .new_base_i (drv_base_i),
    .new_len_i  (drv_len_i),
    .new_perm_i (drv_perm_i),
    .res_o      (drv_res),
    .res_tag_o  (drv_res_tag)
  );

  // fixed priority: tag, seal, permission, bounds
  always_comb begin
    if (!chk_tag_i)     cause_d = FLT_TAG;
    else if (sealed)    cause_d = FLT_SEAL;
    else if (!perm_ok)  cause_d = FLT_PERM;
    else if (!in_bounds) cause_d = FLT_BOUNDS;
    else                cause_d = FLT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_vq  <= 1'b0;
      cause_q <= FLT_NONE;
      ok_q    <= 1'b0;
    end else begin
      chk_vq <= chk_valid_i;
      if (chk_valid_i) begin
        cause_q <= cause_d;
        ok_q    <= (cause_d == FLT_NONE);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_vq    <= 1'b0;
      drv_cap_q <= '0;
      drv_tag_q <= 1'b0;
    end else begin
      drv_vq <= drv_valid_i;
      if (drv_valid_i) begin
        drv_cap_q <= drv_res;
        drv_tag_q <= drv_res_tag;
      end
    end
  end

  assign chk_valid_o = chk_vq;
  assign chk_cause_o = cause_q;
  assign chk_ok_o    = ok_q;
  assign drv_valid_o = drv_vq;
  assign drv_cap_o   = drv_cap_q;
  assign drv_tag_o   = drv_tag_q;

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i |=> chk_valid_o) else $error("latency"); // R2
  AST_TAG_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && !chk_tag_i) |=> (chk_cause_o == 3'd1 && !chk_ok_o)) else $error("tag"); // R3
  AST_SEAL_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && chk_tag_i && chk_cap_i[CAP_W-1]) |=> (chk_cause_o == 3'd2)) else $error("seal"); // R4
  AST_NO_FORGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_valid_i && !drv_tag_i) |=> !drv_tag_o) else $error("forge"); // R8
  AST_NO_PERM_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_valid_i && |(drv_perm_i & ~drv_cap_i[CAP_W-1 -: PERM_W])) |=> !drv_tag_o) else $error("perm grow"); // R8
  AST_ADDR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_valid_i |=> (drv_cap_o[ADDR_W-1:0] == $past(drv_cap_i[ADDR_W-1:0]))) else $error("addr"); // R9
endmodule

// File: tb/cap_guard_tb.sv
module cap_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         chk_v = 0, chk_tag = 0, drv_v = 0, drv_tag = 0;
  logic [127:0] chk_cap = '0, drv_cap = '0;
  logic [1:0]   chk_kind = '0;
  logic [4:0]   chk_size = '0;
  logic [31:0]  drv_base = '0;
  logic [27:0]  drv_len = '0;
  logic [3:0]   drv_perm = '0;
  logic         chk_vo, chk_ok, drv_vo, drv_tag_o;
  logic [2:0]   chk_cause;
  logic [127:0] drv_cap_o;

  cap_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .chk_valid_i(chk_v), .chk_cap_i(chk_cap), .chk_tag_i(chk_tag),
    .chk_kind_i(chk_kind), .chk_size_i(chk_size),
    .chk_valid_o(chk_vo), .chk_cause_o(chk_cause), .chk_ok_o(chk_ok),
    .drv_valid_i(drv_v), .drv_cap_i(drv_cap), .drv_tag_i(drv_tag),
    .drv_base_i(drv_base), .drv_len_i(drv_len), .drv_perm_i(drv_perm),
    .drv_valid_o(drv_vo), .drv_cap_o(drv_cap_o), .drv_tag_o(drv_tag_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // R1 layout: perm [127:124] {seal,exec,write,read}, len, base, addr
  function automatic logic [127:0] mk(logic [3:0] p, logic [27:0] l, logic [31:0] b, logic [63:0] a);
    return {p, l, b, a};
  endfunction

  function automatic logic [2:0] ref_cause(logic [127:0] c, logic t, logic [1:0] k, logic [4:0] n);
    longint unsigned lo, hi, a, sz;
    logic have;
    if (!t) return 3'd1;
    if (c[127]) return 3'd2;
    have = (k == 2'd0) ? c[124] : (k == 2'd1) ? c[125] : (k == 2'd2) ? c[126] : 1'b0;
    if (!have) return 3'd3;
    lo = longint'(c[95:64]);
    hi = lo + longint'(c[123:96]);
    a  = c[63:0];
    sz = longint'(n);
    if (a < lo || sz > hi || a > hi - sz) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic ref_tag(logic [127:0] c, logic t, logic [31:0] nb, logic [27:0] nl, logic [3:0] np);
    longint unsigned ob, ot, nt;
    ob = longint'(c[95:64]);
    ot = ob + longint'(c[123:96]);
    nt = longint'(nb) + longint'(nl);
    return t && (longint'(nb) >= ob) && (nt <= ot) && ((np & ~c[127:124]) == 4'd0);
  endfunction

  // reference model, updated at each clock
  logic         e_cv, e_ok, e_dv, e_tag;
  logic [2:0]   e_cause;
  logic [127:0] e_cap;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_cv <= 0; e_ok <= 0; e_cause <= 0; e_dv <= 0; e_tag <= 0; e_cap <= '0;
    end else begin
      e_cv <= chk_v;
      if (chk_v) begin
        e_cause <= ref_cause(chk_cap, chk_tag, chk_kind, chk_size);
        e_ok    <= (ref_cause(chk_cap, chk_tag, chk_kind, chk_size) == 3'd0);
      end
      e_dv <= drv_v;
      if (drv_v) begin
        e_cap <= {drv_perm, drv_len, drv_base, drv_cap[63:0]};
        e_tag <= ref_tag(drv_cap, drv_tag, drv_base, drv_len, drv_perm);
      end
    end
  end

  task automatic cmp(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        cmp("R10", "reset outs", {chk_vo, chk_cause, chk_ok, drv_vo, drv_tag_o, drv_cap_o == '0},
            {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1});
      end else begin
        cmp("R2", "chk valid", chk_vo, e_cv);
        cmp("R2", "drv valid", drv_vo, e_dv);
        case (e_cause)
          3'd1: cmp("R3", "cause", chk_cause, e_cause);
          3'd2: cmp("R4", "cause", chk_cause, e_cause);
          3'd3: cmp("R5", "cause", chk_cause, e_cause);
          3'd4: cmp("R6", "cause", chk_cause, e_cause);
          default: cmp("R7", "cause", chk_cause, e_cause);
        endcase
        cmp("R7", "ok", chk_ok, e_ok);
        cmp("R1", "drv addr", drv_cap_o[63:0], e_cap[63:0]);
        cmp("R9", "drv fields", drv_cap_o[127:64], e_cap[127:64]);
        cmp("R8", "drv tag", drv_tag_o, e_tag);
        if (e_cv && e_dv) cmp("R11", "joint", {chk_cause, drv_tag_o}, {e_cause, e_tag});
      end
    end
  end

  task automatic do_chk(logic [127:0] c, logic t, logic [1:0] k, logic [4:0] n);
    chk_v = 1; chk_cap = c; chk_tag = t; chk_kind = k; chk_size = n;
  endtask
  task automatic do_drv(logic [127:0] c, logic t, logic [31:0] b, logic [27:0] l, logic [3:0] p);
    drv_v = 1; drv_cap = c; drv_tag = t; drv_base = b; drv_len = l; drv_perm = p;
  endtask
  task automatic tick();
    @(negedge clk);
    chk_v = 0; drv_v = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [127:0] c;
    c = mk(4'b0111, 28'h100, 32'h1000, 64'h1000);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3/R7 tag clear beats seal
    do_chk(mk(4'b1000, 28'h100, 32'h1000, 64'h1000), 0, 2'd0, 5'd4); tick();
    // R4 sealed, all kinds
    for (int k = 0; k < 3; k++) begin do_chk(mk(4'b1111, 28'h100, 32'h1000, 64'h1000), 1, 2'(k), 5'd1); tick(); end
    // R5 permissions
    do_chk(mk(4'b0110, 28'h100, 32'h1000, 64'h1000), 1, 2'd0, 5'd4); tick();
    do_chk(mk(4'b0101, 28'h100, 32'h1000, 64'h1000), 1, 2'd1, 5'd4); tick();
    do_chk(mk(4'b0011, 28'h100, 32'h1000, 64'h1000), 1, 2'd2, 5'd4); tick();
    do_chk(c, 1, 2'd3, 5'd4); tick();
    // R7 perm beats bounds
    do_chk(mk(4'b0010, 28'h10, 32'h1000, 64'h0), 1, 2'd0, 5'd4); tick();
    // R6 bounds edges
    do_chk(mk(4'b0111, 28'h100, 32'h1000, 64'h1000), 1, 2'd0, 5'd16); tick();
    do_chk(mk(4'b0111, 28'h100, 32'h1000, 64'h10f0), 1, 2'd1, 5'd16); tick();
    do_chk(mk(4'b0111, 28'h100, 32'h1000, 64'h10f1), 1, 2'd1, 5'd16); tick();
    do_chk(mk(4'b0111, 28'h100, 32'h1000, 64'h0fff), 1, 2'd2, 5'd1); tick();
    do_chk(mk(4'b0111, 28'h100, 32'h1000, 64'hffff_ffff_ffff_fff8), 1, 2'd0, 5'd16); tick();
    do_chk(mk(4'b0111, 28'hfff_ffff, 32'hffff_fff0, 64'h1_0fff_ffe0), 1, 2'd0, 5'd16); tick();
    // R2 idle holds
    repeat (3) tick();
    // R8/R9 derive cases
    do_drv(c, 1, 32'h1000, 28'h100, 4'b0111); tick();
    do_drv(c, 1, 32'h0fff, 28'h10, 4'b0001); tick();
    do_drv(c, 1, 32'h1010, 28'hf1, 4'b0001); tick();
    do_drv(c, 1, 32'h1010, 28'hf0, 4'b0001); tick();
    do_drv(c, 1, 32'h1010, 28'h10, 4'b1001); tick();
    do_drv(c, 0, 32'h1010, 28'h10, 4'b0001); tick();
    do_drv(mk(4'b0111, 28'hfff_ffff, 32'hffff_ff00, 64'h5), 1, 32'hffff_fff0, 28'hff_ffff, 4'b0001); tick();
    // R11 both in one cycle on the same capability
    do_chk(c, 1, 2'd0, 5'd8); do_drv(c, 1, 32'h1000, 28'h80, 4'b0001); tick();
    do_chk(c, 0, 2'd1, 5'd8); do_drv(c, 1, 32'h1000, 28'h80, 4'b1000); tick();
    // randomized mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] b; logic [27:0] l; logic [63:0] a;
      b = $urandom; l = 28'($urandom % 512);
      a = 64'(b) + 64'($urandom % 600) - 64'd20;
      if ($urandom % 2) do_chk(mk(4'($urandom), l, b, a), ($urandom % 8) != 0, 2'($urandom), 5'($urandom));
      if ($urandom % 2) do_drv(mk(4'($urandom), l, b, a), ($urandom % 8) != 0,
                               b + 32'($urandom % 16) - 32'd4, 28'($urandom % 530), 4'($urandom));
      tick();
    end
    repeat (2) tick();
    finish_run();
  end
endmodule